// File: doc/BRIEF.md
# Clock Output Lane Gating

This block decides, for every clock output lane, whether the lane toggles, is held stopped, or has its output driver switched off. Each lane receives its own free-running clock. The block combines five controls into a single gate for that lane: a per-lane enable bit from the control registers, an active-low output-enable pin on selected serial-reference lanes, a stop pin for the processor lanes, a stop pin for the peripheral and serial-reference lanes, and a global power-down input. The stop pin for the peripheral and serial-reference lanes respects a per-lane free-running flag, and one peripheral lane is always exempt from it.

Lanes are numbered as follows. Processor lanes come first, at indices 0 to N_CPU-1. The serial-reference lanes follow, at indices N_CPU to N_CPU+N_SRC-1. The single-ended peripheral lanes come last. Processor and serial-reference lanes are differential and have a true output and a complement output. Peripheral lanes have one output.

Each lane brings its control request into its own clock domain through a synchronizer. The lane then updates its gate only on a falling edge of its clock. A start or a stop therefore never produces a shortened pulse.

Top module: `clk_out_gate`

## Requirements
- R1: While `rst_n_i` is low, every true and single-ended output is low, every complement output is high and every `drv_en_o` bit is low.
- R2: A lane whose `reg_en_i` bit is 0 drives its `drv_en_o` bit low and is held stopped, whatever the other controls are. A lane whose bit is 1 drives `drv_en_o` high. Register disable has the highest priority.
- R3: While `pwr_dn_i` is high, every lane is stopped. Power-down overrides the free-running flags and the exempt lane, and it does not change `drv_en_o`.
- R4: While `cpu_stop_n_i` is low, the processor lanes are stopped and no other lane is affected. `free_run_i` has no effect on processor lanes.
- R5: While `pci_stop_n_i` is low, every serial-reference lane and every peripheral lane is stopped, except lanes whose `free_run_i` bit is 1.
- R6: The peripheral lane at index N_CPU+N_SRC+FREE_PCI is never stopped by `pci_stop_n_i`. With the defaults this is lane 6.
- R7: Serial-reference lane j runs only while `oe_n_i[j]` is low, provided bit j of SRC_OE_MASK is 1. With the default mask 4'b0101, the pins serve lanes 2 and 4. Pins of unmasked lanes have no effect. A high pin stops a lane even when that lane is flagged free-running.
- R8: A control change reaches the gate after STAGES rising edges of the lane clock and takes effect at the falling edge that follows. A running lane's output follows its clock only while the clock is high and is low throughout the low phase.
- R9: On differential lanes the complement output is always the inverse of the true output. A stopped differential lane therefore holds true low and complement high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset |
| lane_clk_i | input | N_LANE | Free-running clock of each lane |
| reg_en_i | input | N_LANE | Per-lane register enable (1 = enabled) |
| free_run_i | input | N_LANE | Per-lane exemption from the peripheral stop pin |
| oe_n_i | input | N_SRC | Active-low output-enable pins for the serial-reference lanes |
| pci_stop_n_i | input | 1 | Active-low stop for the serial-reference and peripheral lanes |
| cpu_stop_n_i | input | 1 | Active-low stop for the processor lanes |
| pwr_dn_i | input | 1 | Active-high global power-down |
| diff_t_o | output | N_DIFF | True outputs of the differential lanes |
| diff_c_o | output | N_DIFF | Complement outputs of the differential lanes |
| se_o | output | N_PCI | Single-ended peripheral lane outputs |
| drv_en_o | output | N_LANE | Per-lane output driver enable (0 = tri-state) |

## Verification
The bench changes a control just after a rising edge. The change is then captured on the next two rising edges, and the gate moves on the falling edge after the second of them. The new gate value is therefore first visible in the high phase that follows the third rising edge. Every table row and every directed test samples 1 ns after that third edge, while the clock is high, so a running lane reads 1 and a stopped lane reads 0. A separate latency test samples after only two rising edges and expects the old state. Another test samples in the low phase and expects every true output to be low. The checker module states its stopped-lane properties only after the causing input has been held for four falling edges, which covers the same pipeline depth.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;

   typedef enum logic [1:0] {
      LANE_CPU = 2'd0,
      LANE_SRC = 2'd1,
      LANE_PCI = 2'd2
   } lane_kind_e;

   // Class of a flat lane index: processor lanes first, then serial-reference, then peripheral
   function automatic lane_kind_e lane_kind(input int idx, input int n_cpu, input int n_src);
      if (idx < n_cpu)
         return LANE_CPU;
      else if (idx < n_cpu + n_src)
         return LANE_SRC;
      else
         return LANE_PCI;
   endfunction

   // Run request: disable first, then power-down, then the stop conditions
   function automatic logic run_request(input logic en, input logic pd,
                                        input logic stop, input logic oe_blk);
      logic r;
      if (!en)
         r = 1'b0;
      else if (pd)
         r = 1'b0;
      else if (stop || oe_blk)
         r = 1'b0;
      else
         r = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/clk_out_gate_sync.sv
module clk_out_gate_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int k = 0; k < STAGES; k++)
            stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++)
            stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clk_out_gate_cell.sv
module clk_out_gate_cell (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic run_i,
   input  logic en_i,
   output logic t_o,
   output logic den_o
);

   logic run_q;
   logic den_q;

   // Updated only while the lane clock is low, so no shortened pulse appears
   always_ff @(negedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         run_q <= 1'b0;
         den_q <= 1'b0;
      end else begin
         run_q <= run_i & en_i;
         den_q <= en_i;
      end
   end

   assign t_o   = clk_i & run_q;
   assign den_o = den_q;

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
   import clk_out_gate_pkg::*;
#(
   parameter int               N_CPU       = 2,
   parameter int               N_SRC       = 4,
   parameter int               N_PCI       = 3,
   parameter int               FREE_PCI    = 0,
   parameter logic [N_SRC-1:0] SRC_OE_MASK = 4'b0101,
   parameter int               STAGES      = 2,
   localparam int              N_DIFF      = N_CPU + N_SRC,
   localparam int              N_LANE      = N_DIFF + N_PCI
) (
   input  logic              rst_n_i,
   input  logic [N_LANE-1:0] lane_clk_i,
   input  logic [N_LANE-1:0] reg_en_i,
   input  logic [N_LANE-1:0] free_run_i,
   input  logic [N_SRC-1:0]  oe_n_i,
   input  logic              pci_stop_n_i,
   input  logic              cpu_stop_n_i,
   input  logic              pwr_dn_i,
   output logic [N_DIFF-1:0] diff_t_o,
   output logic [N_DIFF-1:0] diff_c_o,
   output logic [N_PCI-1:0]  se_o,
   output logic [N_LANE-1:0] drv_en_o
);

   // Elaboration-time parameter checks
   if (STAGES < 2) begin : g_bad_stages
      $error("clk_out_gate: STAGES must be at least 2");
   end
   if (N_CPU < 1 || N_SRC < 1 || N_PCI < 1) begin : g_bad_counts
      $error("clk_out_gate: every lane class needs at least one lane");
   end
   if (FREE_PCI < 0 || FREE_PCI >= N_PCI) begin : g_bad_free
      $error("clk_out_gate: FREE_PCI must index a peripheral lane");
   end

   for (genvar i = 0; i < N_LANE; i++) begin : g_lane
      localparam lane_kind_e KIND   = lane_kind(i, N_CPU, N_SRC);
      localparam bit         EXEMPT = (i == N_DIFF + FREE_PCI);

      logic       oe_blk;
      logic       stop_hit;
      logic       run_req;
      logic [1:0] sync_q;
      logic       lane_t;

      if (KIND == LANE_SRC) begin : g_oe
         assign oe_blk = SRC_OE_MASK[i-N_CPU] & oe_n_i[i-N_CPU];
      end else begin : g_no_oe
         assign oe_blk = 1'b0;
      end

      // Processor lanes answer only their own stop pin; the others honour free-run and the exempt lane
      assign stop_hit = (KIND == LANE_CPU) ? ~cpu_stop_n_i
                      : (~pci_stop_n_i & ~free_run_i[i] & ~EXEMPT);

      assign run_req = run_request(reg_en_i[i], pwr_dn_i, stop_hit, oe_blk);

      clk_out_gate_sync #(
         .W      (2),
         .STAGES (STAGES)
      ) u_sync (
         .clk_i   (lane_clk_i[i]),
         .rst_n_i (rst_n_i),
         .d_i     ({reg_en_i[i], run_req}),
         .q_o     (sync_q)
      );

      clk_out_gate_cell u_cell (
         .clk_i   (lane_clk_i[i]),
         .rst_n_i (rst_n_i),
         .run_i   (sync_q[0]),
         .en_i    (sync_q[1]),
         .t_o     (lane_t),
         .den_o   (drv_en_o[i])
      );

      if (i < N_DIFF) begin : g_diff
         assign diff_t_o[i] = lane_t;
         assign diff_c_o[i] = ~lane_t;
      end else begin : g_se
         assign se_o[i-N_DIFF] = lane_t;
      end
   end

endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
   parameter int               N_CPU       = 2,
   parameter int               N_SRC       = 4,
   parameter int               N_PCI       = 3,
   parameter int               FREE_PCI    = 0,
   parameter logic [N_SRC-1:0] SRC_OE_MASK = 4'b0101,
   localparam int              N_DIFF      = N_CPU + N_SRC,
   localparam int              N_LANE      = N_DIFF + N_PCI
) (
   input logic              rst_n_i,
   input logic [N_LANE-1:0] lane_clk_i,
   input logic [N_LANE-1:0] reg_en_i,
   input logic [N_LANE-1:0] free_run_i,
   input logic [N_SRC-1:0]  oe_n_i,
   input logic              pci_stop_n_i,
   input logic              cpu_stop_n_i,
   input logic              pwr_dn_i,
   input logic [N_DIFF-1:0] diff_t_o,
   input logic [N_PCI-1:0]  se_o,
   input logic [N_LANE-1:0] drv_en_o
);

   for (genvar i = 0; i < N_LANE; i++) begin : g_lane
      localparam bit IS_CPU = (i < N_CPU);
      localparam bit EXEMPT = (i == N_DIFF + FREE_PCI);

      logic t_lane;
      logic dis_c;
      logic pci_c;

      if (i < N_DIFF) begin : g_d
         assign t_lane = diff_t_o[i];
      end else begin : g_s
         assign t_lane = se_o[i-N_DIFF];
      end

      assign dis_c = ~reg_en_i[i];
      assign pci_c = ~pci_stop_n_i & ~free_run_i[i] & ~IS_CPU & ~EXEMPT;

      AST_DISABLE_TRISTATE: assert property (@(negedge lane_clk_i[i]) disable iff (!rst_n_i)
         (dis_c && $past(dis_c) && $past(dis_c, 2) && $past(dis_c, 3)) |-> (!drv_en_o[i] && !t_lane)); // R2

      AST_PWRDN_STOPS: assert property (@(negedge lane_clk_i[i]) disable iff (!rst_n_i)
         (pwr_dn_i && $past(pwr_dn_i) && $past(pwr_dn_i, 2) && $past(pwr_dn_i, 3)) |-> !t_lane); // R3

      AST_PCI_STOP: assert property (@(negedge lane_clk_i[i]) disable iff (!rst_n_i)
         (pci_c && $past(pci_c) && $past(pci_c, 2) && $past(pci_c, 3)) |-> !t_lane); // R5
   end

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      AST_CPU_STOP: assert property (@(negedge lane_clk_i[c]) disable iff (!rst_n_i)
         (!cpu_stop_n_i && !$past(cpu_stop_n_i) && !$past(cpu_stop_n_i, 2) && !$past(cpu_stop_n_i, 3))
         |-> !diff_t_o[c]); // R4
   end

   for (genvar j = 0; j < N_SRC; j++) begin : g_src
      logic oe_c;
      assign oe_c = SRC_OE_MASK[j] & oe_n_i[j];

      AST_OE_PIN_STOP: assert property (@(negedge lane_clk_i[N_CPU+j]) disable iff (!rst_n_i)
         (oe_c && $past(oe_c) && $past(oe_c, 2) && $past(oe_c, 3)) |-> !diff_t_o[N_CPU+j]); // R7
   end

endmodule

bind clk_out_gate clk_out_gate_chk #(
   .N_CPU       (N_CPU),
   .N_SRC       (N_SRC),
   .N_PCI       (N_PCI),
   .FREE_PCI    (FREE_PCI),
   .SRC_OE_MASK (SRC_OE_MASK)
) u_chk (
   .rst_n_i      (rst_n_i),
   .lane_clk_i   (lane_clk_i),
   .reg_en_i     (reg_en_i),
   .free_run_i   (free_run_i),
   .oe_n_i       (oe_n_i),
   .pci_stop_n_i (pci_stop_n_i),
   .cpu_stop_n_i (cpu_stop_n_i),
   .pwr_dn_i     (pwr_dn_i),
   .diff_t_o     (diff_t_o),
   .se_o         (se_o),
   .drv_en_o     (drv_en_o)
);

// File: tb/clk_out_gate_tb.sv
`timescale 1ns/1ps
module clk_out_gate_tb;

   localparam int N_CPU  = 2;
   localparam int N_SRC  = 4;
   localparam int N_PCI  = 3;
   localparam int N_DIFF = N_CPU + N_SRC;
   localparam int N_LANE = N_DIFF + N_PCI;
   localparam int N_VEC  = 13;

   typedef struct packed {
      logic [3:0]        req;
      logic [N_LANE-1:0] en;
      logic [N_LANE-1:0] fr;
      logic [N_SRC-1:0]  oen;
      logic              ps_n;
      logic              cs_n;
      logic              pd;
      logic [N_LANE-1:0] exp_run;
      logic [N_LANE-1:0] exp_den;
   } vec_t;

   // Lanes 0-1 processor, 2-5 serial-reference, 6-8 peripheral (lane 6 exempt); OE pins serve lanes 2 and 4
   localparam vec_t VEC [N_VEC] = '{
      '{4'd2, 9'h1FF, 9'h000, 4'h0, 1'b1, 1'b1, 1'b0, 9'h1FF, 9'h1FF}, // R2 all enabled, all run
      '{4'd4, 9'h1FF, 9'h000, 4'h0, 1'b1, 1'b0, 1'b0, 9'h1FC, 9'h1FF}, // R4 processor stop
      '{4'd6, 9'h1FF, 9'h000, 4'h0, 1'b0, 1'b1, 1'b0, 9'h043, 9'h1FF}, // R6 exempt lane keeps running
      '{4'd5, 9'h1FF, 9'h108, 4'h0, 1'b0, 1'b1, 1'b0, 9'h14B, 9'h1FF}, // R5 free-running lanes 3 and 8
      '{4'd4, 9'h1FF, 9'h003, 4'h0, 1'b1, 1'b0, 1'b0, 9'h1FC, 9'h1FF}, // R4 free-run ignored on processor lanes
      '{4'd7, 9'h1FF, 9'h000, 4'hF, 1'b1, 1'b1, 1'b0, 9'h1EB, 9'h1FF}, // R7 only masked pins act
      '{4'd2, 9'h1DE, 9'h000, 4'h0, 1'b1, 1'b1, 1'b0, 9'h1DE, 9'h1DE}, // R2 lanes 0 and 5 disabled
      '{4'd2, 9'h1FE, 9'h000, 4'h0, 1'b1, 1'b0, 1'b0, 9'h1FC, 9'h1FE}, // R2 disable with processor stop
      '{4'd3, 9'h1FF, 9'h000, 4'h0, 1'b1, 1'b1, 1'b1, 9'h000, 9'h1FF}, // R3 power-down
      '{4'd2, 9'h0F0, 9'h000, 4'h0, 1'b1, 1'b1, 1'b1, 9'h000, 9'h0F0}, // R2 disable outranks power-down
      '{4'd3, 9'h1FF, 9'h1FF, 4'h0, 1'b1, 1'b1, 1'b1, 9'h000, 9'h1FF}, // R3 overrides free-run and exempt
      '{4'd7, 9'h1FF, 9'h004, 4'h1, 1'b0, 1'b1, 1'b0, 9'h043, 9'h1FF}, // R7 pin beats free-run
      '{4'd5, 9'h1FF, 9'h000, 4'h0, 1'b1, 1'b1, 1'b0, 9'h1FF, 9'h1FF}  // R5 release restores all
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N_LANE-1:0] reg_en, free_run, drv_en;
   logic [N_SRC-1:0]  oe_n;
   logic              pci_stop_n, cpu_stop_n, pwr_dn;
   logic [N_DIFF-1:0] diff_t, diff_c;
   logic [N_PCI-1:0]  se;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   clk_out_gate u_dut (
      .rst_n_i      (rst_n),
      .lane_clk_i   ({N_LANE{clk}}),
      .reg_en_i     (reg_en),
      .free_run_i   (free_run),
      .oe_n_i       (oe_n),
      .pci_stop_n_i (pci_stop_n),
      .cpu_stop_n_i (cpu_stop_n),
      .pwr_dn_i     (pwr_dn),
      .diff_t_o     (diff_t),
      .diff_c_o     (diff_c),
      .se_o         (se),
      .drv_en_o     (drv_en)
   );

   task automatic check(input string tag, input logic [N_LANE-1:0] act, input logic [N_LANE-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      reg_en = v.en; free_run = v.fr; oe_n = v.oen;
      pci_stop_n = v.ps_n; cpu_stop_n = v.cs_n; pwr_dn = v.pd;
   endtask

   function automatic logic [N_LANE-1:0] run_vec();
      return {se, diff_t};
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(VEC[0]);
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state, sampled with the clock high
      check("R1 true/single", run_vec(), '0);
      check("R1 complement", {{N_PCI{1'b0}}, diff_c}, {{N_PCI{1'b0}}, {N_DIFF{1'b1}}});
      check("R1 drive enable", drv_en, '0);
      @(posedge clk); #1 rst_n = 1'b1;

      for (int k = 0; k < N_VEC; k++) begin
         @(posedge clk); #1 drive(VEC[k]);
         repeat (3) @(posedge clk);
         #1;
         check($sformatf("R%0d row %0d run", VEC[k].req, k), run_vec(), VEC[k].exp_run);
         check($sformatf("R%0d row %0d drive", VEC[k].req, k), drv_en, VEC[k].exp_den);
         // R9 complement is the inverse of true
         check($sformatf("R9 row %0d complement", k), {{N_PCI{1'b0}}, diff_c},
               {{N_PCI{1'b0}}, ~VEC[k].exp_run[N_DIFF-1:0]});
      end

      // R8 latency: two rising edges after a stop the lanes still run, the third shows it
      @(posedge clk); #1 cpu_stop_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 check("R8 before gate moves", run_vec(), 9'h1FF);
      @(posedge clk);
      #1 check("R8 after gate moves", run_vec(), 9'h1FC);
      @(posedge clk); #1 cpu_stop_n = 1'b1;
      repeat (3) @(posedge clk);

      // R8 running lanes stay low in the low phase; R9 complement high there
      @(negedge clk); #1;
      check("R8 low phase true", run_vec(), '0);
      check("R9 low phase complement", {{N_PCI{1'b0}}, diff_c}, {{N_PCI{1'b0}}, {N_DIFF{1'b1}}});

      // R1 reset applied while running
      @(posedge clk); #1 rst_n = 1'b0;
      #1;
      check("R1 reset mid-run true", run_vec(), '0);
      check("R1 reset mid-run drive", drv_en, '0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule